// File: doc/BRIEF.md
# Fetch Operation Sampling Unit

This unit picks one instruction-fetch operation out of many and records a profile sample for it. Each fetch operation (a sequential 32-byte block or a fetch started by a redirection such as a taken branch) advances a sampling counter. Instructions are not counted. When the counter meets a programmed limit it wraps to zero and arms the unit. The next accepted fetch is then tagged: its address and redirect indication are latched, and a latency timer runs until that fetch completes. At completion the timer value and the instruction-cache-miss status are latched as well.

The sample then becomes valid and is held for software to read. Counting stops until software pulses a clear, which drops the valid flag and starts a new counting period from zero. An interrupt request is a level that is raised while a sample is valid and interrupts are enabled.

The fetch interface carries one fetch at a time. A request pulse comes with the address and a redirect bit. A later completion pulse comes with the cache-miss status. The completion of a tagged fetch arrives at least one cycle after its request.

Top module: `fetch_sampler`

## Requirements
- R1: After reset `smp_valid`, `irq`, `smp_lat`, `smp_addr`, `smp_ic_miss` and `smp_redirect` are all 0.
- R2: A request counts when it arrives with `cfg_en` high, no valid sample and no tagged fetch in flight. If the count already equals `cfg_max_cnt`, that request resets the count to 0 and arms the unit; otherwise it adds one. The first request after arming is tagged, so with a limit M the tagged fetch is the (M+2)-th counted request after reset or clear.
- R3: `smp_addr` holds the tagged request's address exactly as presented, with no alignment, even when it is odd.
- R4: `smp_lat` equals the number of clock edges from the edge that samples the tagged request to the edge that samples its completion. A completion on the next edge gives 1.
- R5: The latency saturates at 2^LAT_W-1 and never wraps.
- R6: `smp_redirect` is taken from the tagged request. `smp_ic_miss` is taken from its completion.
- R7: While `smp_valid` is 1, requests are not counted and every sample field stays unchanged.
- R8: A `smp_clear` pulse while a sample is valid drops `smp_valid` and restarts counting from zero. A request in the same cycle as that clear is not counted.
- R9: `irq` is high exactly when `smp_valid` and `cfg_irq_en` are both 1.
- R10: Requests seen while `cfg_en` is 0 are not counted.
- R11: A request that arrives while the tagged fetch is in flight (such as a late redirect) is not counted. It does not cancel the sample, which is still reported with the tagged fetch's own fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Sampling enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_max_cnt | input | CNT_W | Fetch count limit |
| smp_clear | input | 1 | Pulse: discard sample and re-arm counting |
| fetch_req | input | 1 | Fetch operation started |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_redirect | input | 1 | Fetch was started by a redirection |
| fetch_done | input | 1 | Outstanding fetch completed |
| fetch_ic_miss | input | 1 | Completed fetch missed the instruction cache |
| smp_valid | output | 1 | Sample record is valid |
| smp_addr | output | ADDR_W | Tagged fetch address |
| smp_lat | output | LAT_W | Tagged fetch latency in cycles |
| smp_ic_miss | output | 1 | Tagged fetch missed the cache |
| smp_redirect | output | 1 | Tagged fetch was redirect-initiated |
| irq | output | 1 | Interrupt request level |

## Verification
Software's clear can land in the same cycle as a new fetch request. The request must then be dropped, because the old sample is still valid on that edge. The bench drives clear and request together on alternate limits, then expects the tagged fetch to fall exactly limit+2 requests later, with its own address.

A second overlap is a late redirect request arriving while the tagged fetch is timing. The bench injects one mid-flight and checks that the completion still yields the tagged fetch's own address, redirect bit and latency.

// File: rtl/fetch_sampler.sv
module fetch_sampler #(
  parameter int CNT_W  = 16,
  parameter int LAT_W  = 12,
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_irq_en,
  input  logic [CNT_W-1:0]  cfg_max_cnt,
  input  logic              smp_clear,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_redirect,
  input  logic              fetch_done,
  input  logic              fetch_ic_miss,
  output logic              smp_valid,
  output logic [ADDR_W-1:0] smp_addr,
  output logic [LAT_W-1:0]  smp_lat,
  output logic              smp_ic_miss,
  output logic              smp_redirect,
  output logic              irq
);

  localparam logic [LAT_W-1:0] LAT_TOP = '1;

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             busy;
  logic [LAT_W-1:0] lat_run;

  wire take = fetch_req && cfg_en && !smp_valid && !busy;
  wire [LAT_W-1:0] lat_step = (lat_run == LAT_TOP) ? lat_run : lat_run + 1'b1;

  assign irq = smp_valid & cfg_irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      armed        <= 1'b0;
      busy         <= 1'b0;
      lat_run      <= '0;
      smp_valid    <= 1'b0;
      smp_addr     <= '0;
      smp_lat      <= '0;
      smp_ic_miss  <= 1'b0;
      smp_redirect <= 1'b0;
    end else begin
      if (smp_clear && smp_valid) begin
        smp_valid <= 1'b0;
        cnt       <= '0;
        armed     <= 1'b0;
      end else if (take) begin
        if (armed) begin
          armed        <= 1'b0;
          busy         <= 1'b1;
          lat_run      <= '0;
          smp_addr     <= fetch_addr;
          smp_redirect <= fetch_redirect;
        end else if (cnt >= cfg_max_cnt) begin
          cnt   <= '0;
          armed <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (busy) begin
        if (fetch_done) begin
          busy        <= 1'b0;
          smp_valid   <= 1'b1;
          smp_lat     <= lat_step;
          smp_ic_miss <= fetch_ic_miss;
        end else begin
          lat_run <= lat_step;
        end
      end
    end
  end

  // R7 R11
  valid_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && busy));

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(smp_valid) |-> $past(smp_clear));

  // R7
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(smp_valid)) |-> ($stable(smp_addr) && $stable(smp_lat)
      && $stable(smp_ic_miss) && $stable(smp_redirect)));

  // R5
  lat_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(lat_run) == LAT_TOP) |-> lat_run == LAT_TOP);

  // R4
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid) |-> ($past(busy) && $past(fetch_done)));

endmodule

// File: tb/tb_fetch_sampler.sv
module tb_fetch_sampler;
  localparam int CW = 4, LW = 4, AW = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_en = 1, cfg_irq_en = 1, smp_clear = 0;
  logic [CW-1:0] cfg_max_cnt = '0;
  logic fetch_req = 0, fetch_redirect = 0, fetch_done = 0, fetch_ic_miss = 0;
  logic [AW-1:0] fetch_addr = '0;
  logic smp_valid, smp_ic_miss, smp_redirect, irq;
  logic [AW-1:0] smp_addr;
  logic [LW-1:0] smp_lat;

  int n_chk = 0, n_bad = 0, seq = 0;

  fetch_sampler #(.CNT_W(CW), .LAT_W(LW), .ADDR_W(AW)) dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] addr_of(input int s);
    return AW'(16'h3001 + s * 7);
  endfunction

  task automatic fetch(input logic redir, input logic miss, input int lat, input logic late);
    @(negedge clk);
    fetch_req = 1; fetch_addr = addr_of(seq); fetch_redirect = redir; seq++;
    @(negedge clk);
    fetch_req = 0; fetch_redirect = 0;
    for (int i = 0; i < lat - 1; i++) begin
      if (late && i == 0) begin
        fetch_req = 1; fetch_redirect = 1; fetch_addr = 16'hBEEF;
      end
      @(negedge clk);
      fetch_req = 0; fetch_redirect = 0;
    end
    fetch_done = 1; fetch_ic_miss = miss;
    @(negedge clk);
    fetch_done = 0; fetch_ic_miss = 0;
  endtask

  task automatic clear(input logic with_req);
    @(negedge clk);
    smp_clear = 1; fetch_req = with_req; fetch_addr = 16'hDEAD;
    @(negedge clk);
    smp_clear = 0; fetch_req = 0;
  endtask

  task automatic run_period(input int m, input int lat, input logic late, input logic with_clear_req);
    int s_tag;
    logic redir, miss;
    cfg_max_cnt = CW'(m);
    for (int k = 0; k < m + 1; k++) begin
      fetch(1'b0, 1'b1, 2, 1'b0);
      chk(smp_valid, 0, "R2 early");
    end
    s_tag = seq; redir = m[0]; miss = ~m[0];
    fetch(redir, miss, lat, late);
    chk(smp_valid, 1, "R2 tagged");
    chk(smp_addr, addr_of(s_tag), late ? "R11 addr" : "R3 addr");
    chk(smp_lat, (lat > 15) ? 15 : lat, (lat > 15) ? "R5 sat" : "R4 lat");
    chk(smp_redirect, redir, "R6 redirect");
    chk(smp_ic_miss, miss, "R6 miss");
    chk(irq, 1, "R9 irq on");
    cfg_irq_en = 0; #1;
    chk(irq, 0, "R9 irq off");
    cfg_irq_en = 1;
    fetch(1'b1, 1'b0, 3, 1'b0);
    fetch(1'b1, 1'b0, 1, 1'b0);
    chk(smp_addr, addr_of(s_tag), "R7 hold addr");
    chk(smp_lat, (lat > 15) ? 15 : lat, "R7 hold lat");
    clear(with_clear_req);
    chk(smp_valid, 0, "R8 cleared");
    chk(irq, 0, "R9 irq after clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(smp_valid, 0, "R1 valid");
    chk(irq, 0, "R1 irq");
    chk(smp_lat, 0, "R1 lat");
    chk(smp_addr, 0, "R1 addr");
    chk(smp_ic_miss + smp_redirect, 0, "R1 flags");
    rst_n = 1;
    for (int m = 0; m < 6; m++)
      run_period(m, 3 * m + 1, (m % 2 == 0) && m > 0, m[0]);
    run_period(1, 20, 1'b0, 1'b0);
    run_period(3, 15, 1'b1, 1'b1);
    // R10: disabled fetches do not count
    cfg_en = 0;
    for (int k = 0; k < 10; k++) fetch(1'b0, 1'b0, 1, 1'b0);
    chk(smp_valid, 0, "R10 disabled");
    cfg_en = 1;
    run_period(2, 5, 1'b0, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule